// File: doc/BRIEF.md
# Multi-Mode Video Timing Generator

This block derives the synchronisation and blanking framework for a display that is 640 pixels wide. It runs on the dot clock and drives an active-low horizontal sync, an active-low vertical sync and an active-high data-enable. It also reports the column and row of the current active pixel, so a pixel source can address its frame store directly.

A 4-bit mode code picks one of five progressive timing sets: three with an 800-clock line, one with an 848-clock line and one with an 864-clock line. Vertical height is 480 or 400 lines depending on the mode. Every porch, sync width and total is kept in a per-mode table that is a parameter of the block; its default holds the five sets below. Codes 5 through 15 produce the mode 0 timing. The code is read only when a frame begins, so a frame is always built from one table.

A line is ordered as sync, back porch, active pixels, front porch. A frame is ordered as sync lines, back-porch lines, active lines, front-porch lines.

Top module: `vtg_timing_gen`

## Requirements
- R1: While reset is high, hsync_n and vsync_n are 1 and de, pix_x and line_y are 0. hsync_n goes low at the first clock edge after reset is released, which is the start of line 0 of a frame.
- R2: hsync_n is low for exactly the mode's horizontal sync width, and it falls once every line total. The line totals are 800, 800, 800, 848 and 864 clocks for modes 0 to 4, and the sync widths are 96, 96, 96, 64 and 64 clocks.
- R3: vsync_n is low for exactly the mode's vertical sync line count and falls once every frame total. The sync line counts are 2, 2, 2, 8 and 3 for modes 0 to 4, and the frame totals are 525, 449, 525, 440 and 525 lines.
- R4: de first rises (sync + back porch) clocks after a hsync_n falling edge, on the first line after (vertical sync + back porch) lines. It stays high for the mode's active width, and it is high on exactly the mode's active line count per frame. In mode 0 the horizontal back porch is 48 clocks and the vertical back porch is 32 lines.
- R5: pix_x counts 0, 1, 2 and upward on successive clocks while de is high, ending at active width minus 1. line_y gives the active line index starting at 0. Both read 0 whenever de is low.
- R6: vsync_n changes state only on the clock edge one dot clock after a hsync_n falling edge.
- R7: Mode codes 5 through 15 produce exactly the timing of mode code 0.
- R8: A change of the mode code takes effect only at the first line of the next frame. The current frame finishes with the timing it started with.
- R9: de is never high while hsync_n or vsync_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 4 | Timing mode code, read at frame start |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high on active pixels |
| pix_x | output | 10 | Active pixel column, 0 outside active |
| line_y | output | 10 | Active line row, 0 outside active |

## Verification
Each mode code, including reserved codes, is applied from reset and the line period, the hsync width and the vsync width are measured. Comparing these against the five distinct tables shows that the right table was picked and that codes 5 to 15 fold onto mode 0. A full-size mode 0 run reaches the first active line, which confirms the porch offsets and the pixel counter range. A second instance with a shrunken table completes whole frames. It is used to count active lines, to measure frame periods, and to change the mode code in mid-frame, which shows whether the switch waits for the frame boundary.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int CW        = 10;
    localparam int NMODES    = 5;
    localparam int CODE_BITS = 4;

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t act;
        cnt_t fp;
        cnt_t sync;
        cnt_t bp;
    } axis_t;

    typedef struct packed {
        axis_t h;
        axis_t v;
    } timing_t;

    typedef timing_t [NMODES-1:0] table_t;

    typedef enum logic [2:0] {
        M_STD480  = 3'd0,
        M_STD400  = 3'd1,
        M_ALT480  = 3'd2,
        M_ALT400  = 3'd3,
        M_WIDE480 = 3'd4
    } mode_e;

    function automatic axis_t mk_axis(int a, int f, int s, int b);
        axis_t r;
        r.act  = cnt_t'(a);
        r.fp   = cnt_t'(f);
        r.sync = cnt_t'(s);
        r.bp   = cnt_t'(b);
        return r;
    endfunction

    function automatic cnt_t axis_total(axis_t a);
        return a.act + a.fp + a.sync + a.bp;
    endfunction

    function automatic table_t default_table();
        table_t t;
        t[0].h = mk_axis(640, 16, 96, 48);  t[0].v = mk_axis(480, 11, 2, 32);
        t[1].h = mk_axis(640, 16, 96, 48);  t[1].v = mk_axis(400, 12, 2, 35);
        t[2].h = mk_axis(640, 16, 96, 48);  t[2].v = mk_axis(480, 6, 2, 37);
        t[3].h = mk_axis(640, 64, 64, 80);  t[3].v = mk_axis(400, 7, 8, 25);
        t[4].h = mk_axis(640, 64, 64, 96);  t[4].v = mk_axis(480, 3, 3, 39);
        return t;
    endfunction

    localparam table_t DEFAULT_TBL = default_table();

    // Codes outside the implemented set fold onto the first mode.
    function automatic mode_e decode_mode(logic [CODE_BITS-1:0] code);
        if (code < CODE_BITS'(NMODES))
            return mode_e'(code[2:0]);
        return M_STD480;
    endfunction

endpackage

// File: rtl/vtg_mode_sel.sv
module vtg_mode_sel
    import vtg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [CODE_BITS-1:0] code,
    output mode_e                cur
);

    always_ff @(posedge clk) begin
        if (rst || load)
            cur <= decode_mode(code);
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cur));

endmodule

// File: rtl/vtg_axis_counter.sv
module vtg_axis_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    assign wrap = step && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= wrap ? '0 : cnt + W'(1);
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

endmodule

// File: rtl/vtg_out_stage.sv
module vtg_out_stage
    import vtg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  timing_t tm,
    input  cnt_t    hc,
    input  cnt_t    vc,
    output logic    hsync_n,
    output logic    vsync_n,
    output logic    de,
    output cnt_t    px,
    output cnt_t    ln
);

    cnt_t h_lo, h_hi, v_lo, v_hi;
    logic in_h, in_v, de_nx;

    always_comb begin
        h_lo  = tm.h.sync + tm.h.bp;
        h_hi  = h_lo + tm.h.act;
        v_lo  = tm.v.sync + tm.v.bp;
        v_hi  = v_lo + tm.v.act;
        in_h  = (hc >= h_lo) && (hc < h_hi);
        in_v  = (vc >= v_lo) && (vc < v_hi);
        de_nx = in_h && in_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            de      <= 1'b0;
            px      <= '0;
            ln      <= '0;
        end else begin
            hsync_n <= !(hc < tm.h.sync);
            // vertical sync moves one dot clock behind the line start
            if (hc == cnt_t'(1))
                vsync_n <= !(vc < tm.v.sync);
            de <= de_nx;
            px <= de_nx ? hc - h_lo : '0;
            ln <= de_nx ? vc - v_lo : '0;
        end
    end

    // R9
    de_sync_excl_chk: assert property (@(posedge clk) disable iff (rst)
        de |-> (hsync_n && vsync_n));

    // R6
    vs_edge_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vsync_n) |-> (!hsync_n && !$past(hsync_n)));

    // R5
    px_step_chk: assert property (@(posedge clk) disable iff (rst)
        (de && $past(de)) |-> (px == $past(px) + cnt_t'(1)));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !de |-> (px == '0 && ln == '0));

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
#(
    parameter table_t TABLE = DEFAULT_TBL
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CODE_BITS-1:0] mode_sel,
    output logic                 hsync_n,
    output logic                 vsync_n,
    output logic                 de,
    output logic [CW-1:0]        pix_x,
    output logic [CW-1:0]        line_y
);

    mode_e   cur_mode;
    timing_t tm;
    cnt_t    hc, vc, h_last, v_last;
    logic    h_wrap, frame_end;

    assign tm     = TABLE[cur_mode];
    assign h_last = axis_total(tm.h) - cnt_t'(1);
    assign v_last = axis_total(tm.v) - cnt_t'(1);

    vtg_mode_sel u_mode (
        .clk  (clk),
        .rst  (rst),
        .load (frame_end),
        .code (mode_sel),
        .cur  (cur_mode)
    );

    vtg_axis_counter #(.W(CW)) u_hcnt (
        .clk  (clk),
        .rst  (rst),
        .step (1'b1),
        .last (h_last),
        .cnt  (hc),
        .wrap (h_wrap)
    );

    vtg_axis_counter #(.W(CW)) u_vcnt (
        .clk  (clk),
        .rst  (rst),
        .step (h_wrap),
        .last (v_last),
        .cnt  (vc),
        .wrap (frame_end)
    );

    vtg_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .tm      (tm),
        .hc      (hc),
        .vc      (vc),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .de      (de),
        .px      (pix_x),
        .ln      (line_y)
    );

    // R8
    frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (hc == '0 && vc == '0));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        !h_wrap |=> $stable(vc));

endmodule

// File: tb/vtg_timing_gen_bench.sv
module vtg_timing_gen_bench;
    import vtg_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic [3:0] mode_a = 4'd0, mode_b = 4'd0;
    logic       hs_a, vs_a, de_a, hs_b, vs_b, de_b;
    logic [9:0] px_a, ln_a, px_b, ln_b;

    function automatic table_t small_table();
        table_t t;
        t[0].h = mk_axis(8, 2, 3, 4);  t[0].v = mk_axis(4, 1, 2, 2);
        t[1].h = mk_axis(8, 1, 2, 3);  t[1].v = mk_axis(3, 2, 1, 1);
        t[2].h = mk_axis(8, 2, 2, 2);  t[2].v = mk_axis(3, 1, 1, 1);
        t[3].h = mk_axis(8, 3, 3, 3);  t[3].v = mk_axis(2, 1, 2, 1);
        t[4].h = mk_axis(8, 1, 3, 2);  t[4].v = mk_axis(2, 2, 2, 2);
        return t;
    endfunction
    localparam table_t SMALL_TBL = small_table();

    vtg_timing_gen u_vtg_timing_gen (
        .clk(clk), .rst(rst), .mode_sel(mode_a),
        .hsync_n(hs_a), .vsync_n(vs_a), .de(de_a), .pix_x(px_a), .line_y(ln_a));

    vtg_timing_gen #(.TABLE(SMALL_TBL)) u_vtg_timing_gen_small (
        .clk(clk), .rst(rst), .mode_sel(mode_b),
        .hsync_n(hs_b), .vsync_n(vs_b), .de(de_b), .pix_x(px_b), .line_y(ln_b));

    logic sel = 1'b0;
    logic s_hs, s_vs, s_de;
    logic [9:0] s_px, s_ln;
    assign s_hs = sel ? hs_b : hs_a;
    assign s_vs = sel ? vs_b : vs_a;
    assign s_de = sel ? de_b : de_a;
    assign s_px = sel ? px_b : px_a;
    assign s_ln = sel ? ln_b : ln_a;

    int total = 0, bad = 0;
    bit done = 1'b0;

    int hs_fall [16];
    int n_hs_fall, hs_rise, vs_fall0, vs_fall1, vs_rise;
    int de_rise, de_fall, px_first, px_last, ln_last, de_rises;

    typedef struct packed {
        logic [3:0] code;
        int         htot;
        int         hs;
        int         vs;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  800, 96, 2},
        '{4'd1,  800, 96, 2},
        '{4'd2,  800, 96, 2},
        '{4'd3,  848, 64, 8},
        '{4'd4,  864, 64, 3},
        '{4'd5,  800, 96, 2},   // reserved, R7
        '{4'd9,  800, 96, 2},   // reserved, R7
        '{4'd15, 800, 96, 2}    // reserved, R7
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] ca, input logic [3:0] cb);
        @(negedge clk);
        rst    = 1'b1;
        mode_a = ca;
        mode_b = cb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: inactive outputs while in reset
        chk("R1 hsync_n", int'(hs_a & hs_b), 1);
        chk("R1 vsync_n", int'(vs_a & vs_b), 1);
        chk("R1 de",      int'(de_a | de_b), 0);
        chk("R1 counters", int'(px_a | ln_a | px_b | ln_b), 0);
        rst = 1'b0;
    endtask

    task automatic prof(input logic s, input int n, input int sw_at, input logic [3:0] sw_code);
        logic p_hs, p_vs, p_de;
        logic [9:0] p_px;
        sel = s;
        p_hs = 1'b1; p_vs = 1'b1; p_de = 1'b0; p_px = '0;
        n_hs_fall = 0; hs_rise = -1; vs_fall0 = -1; vs_fall1 = -1; vs_rise = -1;
        de_rise = -1; de_fall = -1; px_first = -1; px_last = -1; ln_last = -1; de_rises = 0;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (p_hs && !s_hs) begin
                if (n_hs_fall < 16) hs_fall[n_hs_fall] = k;
                n_hs_fall++;
            end
            if (!p_hs && s_hs && hs_rise < 0) hs_rise = k;
            if (p_vs && !s_vs) begin
                if (vs_fall0 < 0) vs_fall0 = k;
                else if (vs_fall1 < 0) vs_fall1 = k;
            end
            if (!p_vs && s_vs && vs_rise < 0) vs_rise = k;
            if (!p_de && s_de) begin
                de_rises++;
                ln_last = int'(s_ln);
                if (de_rise < 0) begin
                    de_rise  = k;
                    px_first = int'(s_px);
                end
            end
            if (p_de && !s_de && de_fall < 0) begin
                de_fall = k;
                px_last = int'(p_px);
            end
            p_hs = s_hs; p_vs = s_vs; p_de = s_de; p_px = s_px;
            if (k == sw_at) mode_b = sw_code;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Vector walk on the full-size tables
        for (int i = 0; i < NV; i++) begin
            do_reset(VECS[i].code, 4'd0);
            prof(1'b0, 2 + VECS[i].vs * VECS[i].htot + 5, 0, 4'd0);
            chk("R1 first hsync fall", hs_fall[0], 1);
            chk("R2 line period", hs_fall[1] - hs_fall[0], VECS[i].htot);
            chk("R2 hsync width", hs_rise - hs_fall[0], VECS[i].hs);
            chk("R6 vsync after hsync", vs_fall0, hs_fall[0] + 1);
            chk("R3 vsync width", vs_rise - vs_fall0, VECS[i].vs * VECS[i].htot);
        end

        // Full-size mode 0 down to the first active line: R4, R5
        do_reset(4'd0, 4'd0);
        prof(1'b0, 27990, 0, 4'd0);
        chk("R4 de start", de_rise, 96 + 48 + 1 + 34 * 800);
        chk("R4 de width", de_fall - de_rise, 640);
        chk("R5 first pix_x", px_first, 0);
        chk("R5 last pix_x", px_last, 639);
        chk("R5 first line_y", ln_last, 0);

        // Shrunken table, mode 0: whole frame
        do_reset(4'd0, 4'd0);
        prof(1'b1, 160, 0, 4'd0);
        chk("R2 small line period", hs_fall[1], 18);
        chk("R2 small hsync width", hs_rise, 4);
        chk("R3 small vsync width", vs_rise, 36);
        chk("R3 small frame period", vs_fall1 - vs_fall0, 153);
        chk("R4 small de start", de_rise, 76);
        chk("R4 small de end", de_fall, 84);
        chk("R4 small active lines", de_rises, 4);
        chk("R5 small last pix_x", px_last, 7);
        chk("R5 small last line_y", ln_last, 3);

        // Shrunken table, mode 1
        do_reset(4'd0, 4'd1);
        prof(1'b1, 105, 0, 4'd1);
        chk("R2 small m1 line period", hs_fall[1], 15);
        chk("R2 small m1 hsync width", hs_rise, 3);
        chk("R3 small m1 vsync width", vs_rise, 16);
        chk("R3 small m1 frame period", vs_fall1, 100);
        chk("R4 small m1 de start", de_rise, 34);
        chk("R4 small m1 active lines", de_rises, 3);

        // R7: reserved code on the shrunken table equals mode 0
        do_reset(4'd0, 4'd6);
        prof(1'b1, 160, 0, 4'd6);
        chk("R7 alias line period", hs_fall[1], 18);
        chk("R7 alias vsync width", vs_rise, 36);
        chk("R7 alias active lines", de_rises, 4);

        // R8: mode change in mid-frame waits for the frame boundary
        do_reset(4'd0, 4'd0);
        prof(1'b1, 175, 50, 4'd1);
        chk("R8 old period after switch", hs_fall[3], 52);
        chk("R8 frame boundary", hs_fall[9], 154);
        chk("R8 new line period", hs_fall[10] - hs_fall[9], 14);
        chk("R8 old frame active lines", de_rises, 4);

        // R1: reset applied while running
        do_reset(4'd2, 4'd3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule